// File: doc/BRIEF.md
# Mode-Selectable Timebase Tick Generator

This block turns the sample clock into a slow, regular timebase tick. Two cascaded down-counters do the work. A short prescaler divides the sample clock by a small ratio. A wider period counter then counts the prescaled steps up to a terminal value. The ratio and the terminal value form a preset pair. A single front-end mode input chooses between two pairs: one for the real-sample front end and one for the complex-sample front end. With the defaults, the real pair is ratio 7 and terminal 2885, which gives a period of 20202 clocks. The complex pair is ratio 6 and terminal 4985, which gives a period of 29916 clocks.

Each time the period counter completes a period, the block emits a one-clock tick. At the same moment it sets a sticky tick flag, which stays set until a status-clear strobe arrives. A mode change takes effect only at a tick boundary, so a period that is already running is never cut short or stretched. Only the hardware reset input restarts the timebase. Any software-level reset elsewhere in the chip does not reach these counters.

All pins are plain control and status signals. The block has no data stream, so it carries no valid/ready handshake.

Top module: `tbg_tick_gen`

## Requirements
- R1: While reset is held and after it is released, `tic` and `tic_flag` read 0 until the first tick is produced.
- R2: With `fe_mode` = 0 (real-sample front end), consecutive `tic` pulses are 7 × (2885+1) = 20202 clock cycles apart.
- R3: With `fe_mode` = 1 (complex-sample front end), consecutive `tic` pulses are 6 × (4985+1) = 29916 clock cycles apart.
- R4: The preset pair is loaded from `fe_mode` at the first rising edge after reset is released. The first `tic` is visible after the rising edge that comes one full period later, that is edge number period+1, counting that first edge as 1.
- R5: `tic` is high for exactly one clock cycle per period.
- R6: `tic_flag` becomes 1 on the same edge that raises `tic`, and it stays 1 until a clear.
- R7: `stat_clr` sampled high clears `tic_flag` at that edge. If `stat_clr` coincides with a tick, the set wins and the flag stays 1.
- R8: A change of `fe_mode` during a period does not alter that period. The new preset pair is loaded at the next tick boundary, and the following period uses it.
- R9: The prescaler is a 3-bit down-counter and the period counter is a 13-bit down-counter. Each reloads on underflow and never leaves the range of its largest preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| fe_mode | input | 1 | Front-end mode: 0 real-sample, 1 complex-sample |
| stat_clr | input | 1 | Status-clear strobe, one cycle, clears `tic_flag` |
| tic | output | 1 | One-clock timebase tick |
| tic_flag | output | 1 | Sticky tick status flag |

## Verification
The in-line assertions check four things on every cycle: the tick is one cycle wide, the flag follows the set and clear rules, both counters stay within their preset ranges, and a tick leaves both counters holding the active mode's reload values. The bench scenarios are needed to show the absolute tick spacing for each mode and the exact position of the first tick after reset. They also show that a mid-period mode change is deferred to the boundary, and that a clear coinciding with a tick loses to the set.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

  typedef enum logic {
    FE_REAL = 1'b0,
    FE_CPLX = 1'b1
  } fe_mode_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tbg_preset_sel.sv
module tbg_preset_sel
  import tbg_pkg::*;
#(
  parameter int unsigned PRE_W      = 3,
  parameter int unsigned CNT_W      = 13,
  parameter int unsigned REAL_RATIO = 7,
  parameter int unsigned REAL_TERM  = 2885,
  parameter int unsigned CPLX_RATIO = 6,
  parameter int unsigned CPLX_TERM  = 4985
) (
  input  fe_mode_e           sel,
  output logic [PRE_W-1:0]   ratio_m1,
  output logic [CNT_W-1:0]   term
);

  localparam logic [PRE_W-1:0] REAL_M1 = PRE_W'(REAL_RATIO - 1);
  localparam logic [PRE_W-1:0] CPLX_M1 = PRE_W'(CPLX_RATIO - 1);
  localparam logic [CNT_W-1:0] REAL_TC = CNT_W'(REAL_TERM);
  localparam logic [CNT_W-1:0] CPLX_TC = CNT_W'(CPLX_TERM);

  always_comb begin
    unique case (sel)
      FE_CPLX: begin
        ratio_m1 = CPLX_M1;
        term     = CPLX_TC;
      end
      default: begin
        ratio_m1 = REAL_M1;
        term     = REAL_TC;
      end
    endcase
  end

endmodule

// File: rtl/tbg_prescaler.sv
module tbg_prescaler #(
  parameter int unsigned PRE_W   = 3,
  parameter int unsigned MAX_CNT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] reload,
  output logic             zero,
  output logic [PRE_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == '0)   cnt <= reload;
    else                  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= PRE_W'(MAX_CNT)) else $error("prescaler out of range"); // R9

endmodule

// File: rtl/tbg_period_counter.sv
module tbg_period_counter #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned MAX_CNT = 4985
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic [CNT_W-1:0] term,
  output logic             term_hit,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (init)       cnt <= term;
    else if (step) begin
      if (cnt == '0)     cnt <= term;
      else               cnt <= cnt - 1'b1;
    end
  end

  assign term_hit = step && (cnt == '0);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_CNT)) else $error("period counter out of range"); // R9

endmodule

// File: rtl/tbg_status.sv
module tbg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_evt)  flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag) else $error("flag not set"); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag) else $error("flag not cleared"); // R7

endmodule

// File: rtl/tbg_tick_gen.sv
module tbg_tick_gen
  import tbg_pkg::*;
#(
  parameter int unsigned REAL_RATIO = 7,
  parameter int unsigned REAL_TERM  = 2885,
  parameter int unsigned CPLX_RATIO = 6,
  parameter int unsigned CPLX_TERM  = 4985
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fe_mode,
  input  logic stat_clr,
  output logic tic,
  output logic tic_flag
);

  localparam int unsigned MAX_RATIO = max_u(REAL_RATIO, CPLX_RATIO);
  localparam int unsigned MAX_TERM  = max_u(REAL_TERM, CPLX_TERM);
  localparam int unsigned PRE_W     = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;
  localparam int unsigned CNT_W     = (MAX_TERM > 1) ? $clog2(MAX_TERM + 1) : 1;

  logic             loaded;
  fe_mode_e         act_mode;
  fe_mode_e         sel_mode;
  logic             take_new;
  logic             pre_zero;
  logic             step;
  logic             boundary;
  logic [PRE_W-1:0] ratio_m1;
  logic [CNT_W-1:0] term;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] per_cnt;

  // The mode input is taken only at start-up and at tick boundaries.
  assign take_new = !loaded || boundary;
  assign sel_mode = take_new ? fe_mode_e'(fe_mode) : act_mode;
  assign step     = loaded && pre_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded   <= 1'b0;
      act_mode <= FE_REAL;
      tic      <= 1'b0;
    end else begin
      loaded   <= 1'b1;
      act_mode <= sel_mode;
      tic      <= boundary;
    end
  end

  tbg_preset_sel #(
    .PRE_W(PRE_W), .CNT_W(CNT_W),
    .REAL_RATIO(REAL_RATIO), .REAL_TERM(REAL_TERM),
    .CPLX_RATIO(CPLX_RATIO), .CPLX_TERM(CPLX_TERM)
  ) u_sel (
    .sel(sel_mode), .ratio_m1(ratio_m1), .term(term)
  );

  tbg_prescaler #(.PRE_W(PRE_W), .MAX_CNT(MAX_RATIO - 1)) u_pre (
    .clk(clk), .rst_n(rst_n), .reload(ratio_m1), .zero(pre_zero), .cnt(pre_cnt)
  );

  tbg_period_counter #(.CNT_W(CNT_W), .MAX_CNT(MAX_TERM)) u_per (
    .clk(clk), .rst_n(rst_n), .init(!loaded), .step(step), .term(term),
    .term_hit(boundary), .cnt(per_cnt)
  );

  tbg_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_evt(boundary), .clr(stat_clr), .flag(tic_flag)
  );

  AST_TIC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tic |=> !tic) else $error("tick wider than one cycle"); // R5
  AST_TIC_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tic |-> tic_flag) else $error("tick without flag"); // R6
  AST_TIC_RELOADED: assert property (@(posedge clk) disable iff (!rst_n)
    tic |-> (pre_cnt == ratio_m1) && (per_cnt == term))
    else $error("counters not reloaded at boundary"); // R8
  AST_NO_TIC_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !tic && !tic_flag) else $error("output before load"); // R1

endmodule

// File: tb/test_tbg_tick_gen.sv
module test_tbg_tick_gen;

  localparam time CLK_PERIOD = 10ns;
  localparam int  N_REAL = 7 * 2886;
  localparam int  N_CPLX = 6 * 4986;
  localparam int  WATCHDOG = 190000;

  typedef struct {
    int    gap;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fe_mode = 1'b0;
  logic stat_clr = 1'b0;
  logic tic;
  logic tic_flag;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_tic = 1;
  int ticks_seen = 0;
  bit prev_tic = 1'b0;
  bit done = 1'b0;
  exp_t expq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tbg_tick_gen i_tbg_tick_gen (
    .clk(clk), .rst_n(rst_n), .fe_mode(fe_mode), .stat_clr(stat_clr),
    .tic(tic), .tic_flag(tic_flag)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_gap(input int gap, input string tag);
    exp_t e;
    e.gap = gap;
    e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: compares tick spacing against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (tic && prev_tic) check(1'b0, "R5", 2, 1);
      if (tic) begin
        ticks_seen++;
        check(tic_flag == 1'b1, "R6", tic_flag, 1);
        if (expq.size() == 0) begin
          check(1'b0, "R2", cyc - last_tic, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(cyc - last_tic == e.gap, e.tag, cyc - last_tic, e.gap);
        end
        last_tic = cyc;
      end
      prev_tic = tic;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(tic == 1'b0, "R1", tic, 0);
    check(tic_flag == 1'b0, "R1", tic_flag, 0);
    // R4: first gap is measured from the load edge (cycle 1)
    push_gap(N_REAL, "R4");
    push_gap(N_REAL, "R2");
    push_gap(N_REAL, "R8");
    push_gap(N_CPLX, "R3");
    push_gap(N_CPLX, "R3");
    rst_n = 1'b1;
    wait_cyc(5);
    check(tic == 1'b0, "R1", tic, 0);
    check(tic_flag == 1'b0, "R1", tic_flag, 0);

    // R6: flag holds after first tick; R7: clear strobe drops it
    wait_cyc(N_REAL + 11);
    check(ticks_seen == 1, "R4", ticks_seen, 1);
    check(tic_flag == 1'b1, "R6", tic_flag, 1);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    check(tic_flag == 1'b0, "R7", tic_flag, 0);

    // R7: clear coinciding with the second tick loses to the set
    wait_cyc(2 * N_REAL);
    check(tic_flag == 1'b0, "R7", tic_flag, 0);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    check(tic == 1'b1, "R2", tic, 1);
    check(tic_flag == 1'b1, "R7", tic_flag, 1);
    @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    check(tic_flag == 1'b0, "R7", tic_flag, 0);

    // R8: switch to complex mode mid-period
    wait_cyc(2 * N_REAL + 5000);
    fe_mode = 1'b1;
    wait_cyc(1 + 3 * N_REAL + 2 * N_CPLX + 3);
    check(ticks_seen == 5, "R3", ticks_seen, 5);
    check(expq.size() == 0, "R8", expq.size(), 0);
    check(tic_flag == 1'b1, "R6", tic_flag, 1);
    check(tic == 1'b0, "R5", tic, 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d ticks", ticks_seen, 5);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule